// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the test port of a memory device. A four-wire serial interface (test clock, mode select, serial data in, serial data out) and an active-low asynchronous test reset drive it. A sixteen-state controller steps through its states on each rising test-clock edge according to the mode-select level. The controller chooses between an instruction path and a data path, and moves each one through capture, shift and update phases.

A 3-bit instruction selects one of three data registers for the serial path: a 1-bit bypass stage, a 32-bit identification register, or a boundary register. The boundary register covers a parameterised group of input pins and bidirectional data pins, plus one control cell. The control cell decides whether the data pins drive while external test is active.

The block drives the data pins through three outputs: an override flag, a drive enable that applies when the override is set, and the value to drive. Board test uses these to isolate the memory, sample its pins, or apply test patterns to them. The test reset is released on a rising test-clock edge through a two-stage synchroniser.

Top module: `scan_port`

## Requirements
- R1: Five consecutive rising test-clock edges with mode select high put the controller in Test-Logic-Reset from any state, including the middle of a data shift.
- R2: After reset, and on every entry to Test-Logic-Reset, the active instruction is the identification instruction (code 001). In this state the pins are not overridden and serial out is not enabled.
- R3: Capture-IR loads the pattern 001 into the instruction shift stage. The stage shifts out least significant bit first, so the first three serial-out bits are 1, 0, 0.
- R4: Under code 001, Capture-DR loads the 32-bit identification value. Shift-DR then moves it out least significant bit first.
- R5: Under code 111, and under the unassigned codes 011, 101 and 110, a single stage sits between serial in and serial out. It captures 0, so an n-bit scan returns 0 followed by the first n-1 input bits.
- R6: Under code 100, Capture-DR loads the boundary register as {data pins, input pins, control cell}. The control cell is bit 0, nearest serial out, and captures its own update latch. The pins stay in normal operation.
- R7: Under code 010, the data pins are overridden with drive disabled (high impedance). The boundary register is the serial path.
- R8: Under code 000, the data pins are overridden. The drive enable follows the control-cell update latch, and the driven value follows the data-cell update latches. Capture-DR loads the pad values, as for code 100.
- R9: The boundary update latches load from the shift stage only on the falling edge in Update-DR, and only while code 000, 010 or 100 is active. Scans under other instructions leave them unchanged.
- R10: Serial out changes on the falling test-clock edge. Its enable is high only in Shift-IR and Shift-DR.
- R11: A new instruction takes effect only at Update-IR, on the falling edge. While the new code is still in the shift stage, the pin overrides keep the old instruction's values.
- R12: The unassigned codes leave the data pins in normal operation (no override).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pin_in | input | N_IN | Input pin values seen by the boundary cells |
| dq_in | input | N_DQ | Data pad values seen by the boundary cells |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | High while serial out should drive |
| dq_force | output | 1 | Data pins are under test control |
| dq_drive_en | output | 1 | When forced: 1 drives dq_val, 0 is high impedance |
| dq_val | output | N_DQ | Value driven onto the data pins under external test |

## Verification
The assertions assume that mode select and serial in are stable around each rising test-clock edge. They also assume that the test reset is held low long enough for the synchroniser to clear the state before the first enabled check. The stimulus changes mode select and serial in one nanosecond after each rising edge. It holds reset low for several cycles before releasing it. The pin and pad inputs change only while the controller idles in Run-Test/Idle, and never during a capture.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_EX2DR   = 4'h0,
    ST_EX1DR   = 4'h1,
    ST_SHDR    = 4'h2,
    ST_PAUSEDR = 4'h3,
    ST_SELIR   = 4'h4,
    ST_UPDDR   = 4'h5,
    ST_CAPDR   = 4'h6,
    ST_SELDR   = 4'h7,
    ST_EX2IR   = 4'h8,
    ST_EX1IR   = 4'h9,
    ST_SHIR    = 4'hA,
    ST_PAUSEIR = 4'hB,
    ST_RTI     = 4'hC,
    ST_UPDIR   = 4'hD,
    ST_CAPIR   = 4'hE,
    ST_TLR     = 4'hF
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_HIZ    = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  typedef struct packed {
    logic sel_id;
    logic sel_bsr;
    logic ext;
    logic hiz;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [IR_W-1:0] code);
    op_dec_t d;
    d = '0;
    case (code)
      OP_EXTEST: begin d.sel_bsr = 1'b1; d.ext = 1'b1; end
      OP_IDENT:  d.sel_id = 1'b1;
      OP_HIZ:    begin d.sel_bsr = 1'b1; d.hiz = 1'b1; end
      OP_SAMPLE: d.sel_bsr = 1'b1;
      default:   d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;
  logic [2:0] ones_q;

  always_comb begin
    case (state_q)
      ST_TLR:     state_d = tms ? ST_TLR     : ST_RTI;
      ST_RTI:     state_d = tms ? ST_SELDR   : ST_RTI;
      ST_SELDR:   state_d = tms ? ST_SELIR   : ST_CAPDR;
      ST_CAPDR:   state_d = tms ? ST_EX1DR   : ST_SHDR;
      ST_SHDR:    state_d = tms ? ST_EX1DR   : ST_SHDR;
      ST_EX1DR:   state_d = tms ? ST_UPDDR   : ST_PAUSEDR;
      ST_PAUSEDR: state_d = tms ? ST_EX2DR   : ST_PAUSEDR;
      ST_EX2DR:   state_d = tms ? ST_UPDDR   : ST_SHDR;
      ST_UPDDR:   state_d = tms ? ST_SELDR   : ST_RTI;
      ST_SELIR:   state_d = tms ? ST_TLR     : ST_CAPIR;
      ST_CAPIR:   state_d = tms ? ST_EX1IR   : ST_SHIR;
      ST_SHIR:    state_d = tms ? ST_EX1IR   : ST_SHIR;
      ST_EX1IR:   state_d = tms ? ST_UPDIR   : ST_PAUSEIR;
      ST_PAUSEIR: state_d = tms ? ST_EX2IR   : ST_PAUSEIR;
      ST_EX2IR:   state_d = tms ? ST_UPDIR   : ST_SHIR;
      ST_UPDIR:   state_d = tms ? ST_SELDR   : ST_RTI;
      default:    state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // Consecutive-high counter used only by the check below
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)            ones_q <= 3'd0;
    else if (!tms)         ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  // R1
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_q == 3'd5) |-> (state_q == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir,
  output logic            ir_so
);

  logic [IR_W-1:0] sr_q, ir_q;
  logic cap_en, shf_en, upd_en, rst_en;

  assign cap_en = (state == ST_CAPIR);
  assign shf_en = (state == ST_SHIR);
  assign upd_en = (state == ST_UPDIR);
  assign rst_en = (state == ST_TLR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (cap_en) sr_q <= 3'b001;
    else if (shf_en) sr_q <= {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      ir_q <= OP_IDENT;
    else if (rst_en) ir_q <= OP_IDENT;
    else if (upd_en) ir_q <= sr_q;
  end

  assign ir    = ir_q;
  assign ir_so = sr_q[0];

  // R11
  ir_update_only_chk: assert property (@(negedge tck) disable iff (!rst_n)
    !$stable(ir_q) |-> ($past(state) == ST_UPDIR || $past(state) == ST_TLR));

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import scan_port_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_DQ = 4
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  logic            sel,
  input  logic            ext,
  input  logic            hiz,
  input  logic [N_IN-1:0] pin_in,
  input  logic [N_DQ-1:0] dq_in,
  output logic            so,
  output logic            dq_force,
  output logic            dq_drive_en,
  output logic [N_DQ-1:0] dq_val
);

  localparam int L      = N_IN + N_DQ + 1;
  localparam int DQ_LSB = N_IN + 1;

  logic [L-1:0]    sr_q, cap_v;
  logic            ctrl_q;
  logic [N_DQ-1:0] dq_q;
  logic cap_en, shf_en, upd_en;

  assign cap_en = sel && (state == ST_CAPDR);
  assign shf_en = sel && (state == ST_SHDR);
  assign upd_en = sel && (state == ST_UPDDR);
  assign cap_v  = {dq_in, pin_in, ctrl_q};

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (cap_en) sr_q <= cap_v;
    else if (shf_en) sr_q <= {tdi, sr_q[L-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= 1'b0;
    else if (upd_en) ctrl_q <= sr_q[0];
  end

  for (genvar g = 0; g < N_DQ; g++) begin : g_dq_cell
    always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)      dq_q[g] <= 1'b0;
      else if (upd_en) dq_q[g] <= sr_q[DQ_LSB+g];
    end
    assign dq_val[g] = ext & dq_q[g];
  end

  assign so          = sr_q[0];
  assign dq_force    = ext | hiz;
  assign dq_drive_en = ext & ctrl_q;

  // R9
  upd_latch_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
    !$stable({ctrl_q, dq_q}) |-> ($past(state) == ST_UPDDR && $past(sel)));

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_port_pkg::*;
#(
  parameter int          N_IN     = 4,
  parameter int          N_DQ     = 4,
  parameter logic [31:0] ID_VALUE = 32'h0A5C_3F1D
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic [N_IN-1:0] pin_in,
  input  logic [N_DQ-1:0] dq_in,
  output logic            tdo,
  output logic            tdo_en,
  output logic            dq_force,
  output logic            dq_drive_en,
  output logic [N_DQ-1:0] dq_val
);

  localparam int ID_W = 32;

  logic [1:0]      rst_sync_q;
  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so, bsr_so;
  op_dec_t         dec;
  logic [ID_W-1:0] id_q;
  logic            byp_q, tdo_d, shift_any;
  logic            id_cap, id_shf, byp_cap, byp_shf, byp_sel;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
               .ir(ir), .ir_so(ir_so));

  assign dec     = decode_op(ir);
  assign byp_sel = !dec.sel_id && !dec.sel_bsr;

  tap_bsr #(.N_IN(N_IN), .N_DQ(N_DQ)) u_bsr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .sel(dec.sel_bsr), .ext(dec.ext), .hiz(dec.hiz),
    .pin_in(pin_in), .dq_in(dq_in), .so(bsr_so),
    .dq_force(dq_force), .dq_drive_en(dq_drive_en), .dq_val(dq_val));

  assign id_cap  = dec.sel_id && (state == ST_CAPDR);
  assign id_shf  = dec.sel_id && (state == ST_SHDR);
  assign byp_cap = byp_sel && (state == ST_CAPDR);
  assign byp_shf = byp_sel && (state == ST_SHDR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      id_q <= '0;
    else if (id_cap) id_q <= ID_VALUE;
    else if (id_shf) id_q <= {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       byp_q <= 1'b0;
    else if (byp_cap) byp_q <= 1'b0;
    else if (byp_shf) byp_q <= tdi;
  end

  assign shift_any = (state == ST_SHIR) || (state == ST_SHDR);

  always_comb begin
    if (state == ST_SHIR)  tdo_d = ir_so;
    else if (dec.sel_id)   tdo_d = id_q[0];
    else if (dec.sel_bsr)  tdo_d = bsr_so;
    else                   tdo_d = byp_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= shift_any;
    end
  end

  // R10
  tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == ((state == ST_SHIR) || (state == ST_SHDR)));

  // R7
  hiz_force_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ir == OP_HIZ) |-> (dq_force && !dq_drive_en));

  // R12
  unassigned_normal_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ir == 3'b011 || ir == 3'b101 || ir == 3'b110) |-> !dq_force);

  // R2
  tlr_default_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $past(state == ST_TLR) && (state != ST_TLR) |-> (ir == OP_IDENT) && !dq_force);

endmodule

// File: tb/scan_port_tb.sv
`timescale 1ns/1ps
module scan_port_tb;

  localparam logic [31:0] IDV = 32'h0A5C_3F1D;

  logic       tck = 1'b0;
  logic       trst_n, tms_i, tdi_i;
  logic [3:0] pin_in, dq_in;
  logic       tdo, tdo_en, dq_force, dq_drive_en;
  logic [3:0] dq_val;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] exp_v[$];
  string       exp_r[$];
  logic [63:0] act_v[$];
  event        act_ev;

  always #2 tck = ~tck;

  scan_port #(.N_IN(4), .N_DQ(4), .ID_VALUE(IDV)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms_i), .tdi(tdi_i),
    .pin_in(pin_in), .dq_in(dq_in), .tdo(tdo), .tdo_en(tdo_en),
    .dq_force(dq_force), .dq_drive_en(dq_drive_en), .dq_val(dq_val));

  task automatic put_exp(string r, logic [63:0] v);
    exp_r.push_back(r);
    exp_v.push_back(v);
  endtask

  task automatic put_act(logic [63:0] v);
    act_v.push_back(v);
    -> act_ev;
  endtask

  // Monitor: pops expected and actual items in order and compares them
  initial begin
    forever begin
      @(act_ev);
      while (act_v.size() > 0 && exp_v.size() > 0) begin
        logic [63:0] a, e;
        string r;
        a = act_v.pop_front();
        e = exp_v.pop_front();
        r = exp_r.pop_front();
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", r, a, e);
        end
      end
    end
  end

  task automatic step(logic m, logic d);
    @(posedge tck);
    #1;
    tms_i = m;
    tdi_i = d;
  endtask

  task automatic pins_act();
    put_act({58'd0, dq_force, dq_drive_en, dq_val});
  endtask

  // From Run-Test/Idle; returns in Run-Test/Idle after Update-DR
  task automatic scan_dr(int n, logic [63:0] din);
    logic [63:0] dout;
    logic en0;
    dout = '0;
    en0 = 1'b0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      @(negedge tck);
      #0.5;
      dout[i] = tdo;
      if (i == 0) en0 = tdo_en;
    end
    @(posedge tck); #1; tms_i = 1'b1;
    @(posedge tck); #1; tms_i = 1'b0;
    @(posedge tck); #1;
    put_act(dout);
    put_act({63'd0, en0});
  endtask

  task automatic scan_ir(logic [2:0] code);
    logic [63:0] cap;
    logic pre;
    cap = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      @(negedge tck);
      #0.5;
      cap[i] = tdo;
    end
    @(posedge tck); #1; pre = dq_force; tms_i = 1'b1;
    @(posedge tck); #1; tms_i = 1'b0;
    @(posedge tck); #1;
    put_act(cap);
    put_act({63'd0, pre});
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tms_i = 1'b1; tdi_i = 1'b0;
    pin_in = 4'h9; dq_in = 4'h6;
    repeat (4) @(posedge tck);
    #1 trst_n = 1'b1; tms_i = 1'b0;
    repeat (4) @(posedge tck);
    #1;

    // R2 reset state; R10 idle enable low
    put_exp("R10 tdo_en idle", 64'd0); put_act({63'd0, tdo_en});
    put_exp("R2 pins after reset", 64'd0); pins_act();

    // R4 identification under default instruction
    put_exp("R4 id value", {32'd0, IDV});
    put_exp("R10 tdo_en in shift", 64'd1);
    scan_dr(32, 64'd0);

    // R5 bypass
    put_exp("R3 ir capture", 64'd1); put_exp("R11 pre-update force", 64'd0);
    scan_ir(3'b111);
    put_exp("R5 bypass", 64'h6A); put_exp("R10 en", 64'd1);
    scan_dr(8, 64'hB5);

    // R5 / R12 unassigned code
    put_exp("R3 ir capture", 64'd1); put_exp("R11 pre-update force", 64'd0);
    scan_ir(3'b011);
    put_exp("R5 unassigned as bypass", 64'h78); put_exp("R10 en", 64'd1);
    scan_dr(8, 64'h3C);
    put_exp("R12 unassigned pins normal", 64'd0); pins_act();

    // R6 sample and preload ctrl=1 dq=1010
    put_exp("R3 ir capture", 64'd1); put_exp("R11 pre-update force", 64'd0);
    scan_ir(3'b100);
    put_exp("R6 sample capture", 64'h0D2); put_exp("R10 en", 64'd1);
    scan_dr(9, 64'h141);
    put_exp("R6 pins normal", 64'd0); pins_act();

    // R8 external test drives preloaded values
    put_exp("R3 ir capture", 64'd1); put_exp("R11 pre-update force", 64'd0);
    scan_ir(3'b000);
    put_exp("R8 extest drive", 64'h3A); pins_act();
    put_exp("R8 extest pad capture", 64'h0D3); put_exp("R10 en", 64'd1);
    scan_dr(9, 64'h0A0);
    put_exp("R8 extest after update", 64'h25); pins_act();

    // R7 high impedance
    put_exp("R3 ir capture", 64'd1); put_exp("R11 pre-update force", 64'd1);
    scan_ir(3'b010);
    put_exp("R7 hiz pins", 64'h20); pins_act();
    put_exp("R7 hiz capture", 64'h0D2); put_exp("R10 en", 64'd1);
    scan_dr(9, 64'h1FF);

    // R9 bypass scan leaves latches alone
    put_exp("R3 ir capture", 64'd1); put_exp("R11 pre-update force", 64'd1);
    scan_ir(3'b111);
    put_exp("R5 bypass zero", 64'd0); put_exp("R10 en", 64'd1);
    scan_dr(8, 64'd0);
    put_exp("R3 ir capture", 64'd1); put_exp("R11 pre-update force", 64'd0);
    scan_ir(3'b000);
    put_exp("R9 latches kept", 64'h3F); pins_act();

    // R1 five highs from mid-shift
    step(1, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    @(posedge tck); #1;
    put_exp("R1 pins after tms reset", 64'd0); pins_act();
    put_exp("R1 id after tms reset", {32'd0, IDV}); put_exp("R10 en", 64'd1);
    scan_dr(32, 64'd0);

    repeat (4) @(posedge tck);
    #1;
    if (exp_v.size() != 0 || act_v.size() != 0) begin
      n_bad++;
      $display("FAIL queues actual=%0d expected=%0d", act_v.size(), exp_v.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule